// File: doc/BRIEF.md
# Microcoded Memory Pattern Sequencer

This block replays a short program of control words that a host has loaded into a 64-entry internal store. Once a request with a start address is accepted, it presents one word per clock cycle to the downstream memory-pin logic. It keeps presenting words until it reaches a word that marks the end of the pattern. Three flag bits in every word steer the walk. One ends the pattern. One marks the bounds of a single hardware loop. One allows the walk to be redirected to a fixed handler location when any of three exception inputs is raised.

The loop works as follows. The first flagged word the walk meets becomes the loop head. The next flagged word at a different address becomes the loop tail. The body between them, head and tail included, is replayed a number of times taken from a count input when the request is accepted. Once the count is used up, further loop flags are treated as plain words. The request side uses a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request held while it is busy waits, without effect, until the pattern has finished. The word outputs are plain status: `ctrl_valid` marks the cycles in which `cur_word` and `cur_addr` hold a live word, and they are not back-pressured.

Top module: `patseq_top`

## Requirements
- R1: After reset the sequencer is idle: `req_ready`=1, `ctrl_valid`=0, `done`=0.
- R2: A host write with `wr_en`=1 stores `wr_data` at `wr_addr`. Whenever word A is executed, `cur_word` equals the last value written to A. The word's flag bits are: bit 31 end-of-pattern, bit 30 loop mark, bit 29 exception enable.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `ctrl_valid`=1 and `cur_addr` equals the accepted `req_start`. While busy, `req_ready`=0 and `req_valid` has no effect.
- R4: A word with none of the three flags taking effect is followed in the next cycle by the word at the next address, and address 63 is followed by address 0.
- R5: While an end-of-pattern word is executed, `done`=1 for exactly that cycle. In the next cycle the sequencer is idle (`ctrl_valid`=0, `req_ready`=1).
- R6: The first loop-marked word executed becomes the loop head, and the next loop-marked word at another address is the tail. The body runs `loop_cnt` times in total, and a count of 0 runs it once.
- R7: After the final pass through the tail, any later loop-marked words are treated as plain words.
- R8: The loop count and loop tracking are reloaded from `loop_cnt` at every accepted request.
- R9: When the executed word has exception enable set and any of `exc_tea`, `exc_hrst` or `exc_srst` is high, the next word executed is at address 60.
- R10: An exception raised while the executed word has exception enable clear is ignored, and it is not remembered for a later enabled word.
- R11: An end-of-pattern word ends the pattern even if exception enable and an exception input are both set.
- R12: Taking an exception clears the loop head, so the first loop-marked word in the handler starts a new loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host word write strobe |
| wr_addr | input | 6 | Host write address |
| wr_data | input | 32 | Host write data |
| req_valid | input | 1 | Pattern request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_start | input | 6 | Start address of the requested pattern |
| loop_cnt | input | 4 | Loop pass count, sampled on acceptance |
| exc_tea | input | 1 | Transfer-error exception |
| exc_hrst | input | 1 | Hard-reset exception |
| exc_srst | input | 1 | Soft-reset exception |
| ctrl_valid | output | 1 | A word is being executed this cycle |
| cur_addr | output | 6 | Address of the executed word |
| cur_word | output | 32 | Executed word (zero when idle) |
| done | output | 1 | End-of-pattern word executing |

## Verification
The bench sweeps the loop count over all sixteen values against a loop body that is followed by a stray loop-marked word. An off-by-one count shows up as a missing or extra pass. A sequencer that forgets the loop has finished would jump back at the stray word. Requests are issued from the highest count down to zero and then at a middle count again. A design that does not reload its counter would replay the wrong number of passes. Each of the three exception sources is raised on an enabled word. An exception is also raised on a disabled word just before an enabled one, where a design that latches exceptions would branch late. Further cases cover an exception on an end-of-pattern word, a walk across the top of the address space, and a handler entered from inside a loop: a design that keeps the old loop head would bounce from the handler back into the body.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  localparam int WORD_W   = 32;
  localparam int BIT_LAST = 31;
  localparam int BIT_LOOP = 30;
  localparam int BIT_EXEN = 29;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/patseq_store.sv
module patseq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Asynchronous read: the word at the program counter is live in the same cycle.
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/patseq_exc.sv
module patseq_exc #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] src,
  input  logic            active,
  input  logic            exen,
  output logic            hit
);
  logic [NSRC:0] any_chain;

  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | src[g];
  end

  // Only sampled in the cycle of an enabled word; nothing is held over.
  assign hit = active & exen & any_chain[NSRC];
endmodule

// File: rtl/patseq_loop.sv
module patseq_loop #(
  parameter int AW    = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             flush,
  input  logic             step,
  input  logic [AW-1:0]    pc,
  input  logic             flag,
  output logic             take_back,
  output logic [AW-1:0]    back_addr
);
  logic             armed;
  logic             spent;
  logic [AW-1:0]    head;
  logic [CNT_W-1:0] reps;
  logic             at_tail;

  assign at_tail   = flag & armed & ~spent & (pc != head);
  assign take_back = at_tail & (reps != '0);
  assign back_addr = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      spent <= 1'b0;
      head  <= '0;
      reps  <= '0;
    end else if (load) begin
      armed <= 1'b0;
      spent <= 1'b0;
      reps  <= (cnt_in == '0) ? '0 : cnt_in - 1'b1;
    end else if (flush) begin
      armed <= 1'b0;
      spent <= 1'b0;
    end else if (step && flag && !spent) begin
      if (!armed) begin
        armed <= 1'b1;
        head  <= pc;
      end else if (at_tail) begin
        if (reps != '0) reps  <= reps - 1'b1;
        else            spent <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/patseq_top.sv
module patseq_top #(
  parameter int DEPTH    = 64,
  parameter int EXC_ADDR = 60,
  parameter int CNT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(DEPTH)-1:0]   req_start,
  input  logic [CNT_W-1:0]           loop_cnt,
  input  logic                       exc_tea,
  input  logic                       exc_hrst,
  input  logic                       exc_srst,
  output logic                       ctrl_valid,
  output logic [$clog2(DEPTH)-1:0]   cur_addr,
  output logic [31:0]                cur_word,
  output logic                       done
);
  import patseq_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] EXC_PC  = AW'(EXC_ADDR);
  localparam logic [AW-1:0] LAST_PC = AW'(DEPTH - 1);

  seq_state_e           st;
  logic [AW-1:0]        pc;
  logic [AW-1:0]        pc_seq;
  logic [WORD_W-1:0]    word;
  logic                 running;
  logic                 is_last;
  logic                 exc_hit;
  logic                 take_back;
  logic [AW-1:0]        back_addr;
  logic                 accept;

  patseq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(pc), .rd_data(word)
  );

  assign running = (st == ST_RUN);
  assign is_last = running & word[BIT_LAST];
  assign accept  = (st == ST_IDLE) & req_valid;

  patseq_exc #(.NSRC(3)) u_exc (
    .src({exc_srst, exc_hrst, exc_tea}),
    .active(running & ~word[BIT_LAST]),
    .exen(word[BIT_EXEN]),
    .hit(exc_hit)
  );

  patseq_loop #(.AW(AW), .CNT_W(CNT_W)) u_loop (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .cnt_in(loop_cnt),
    .flush(exc_hit),
    .step(running & ~is_last & ~exc_hit),
    .pc(pc), .flag(word[BIT_LOOP]),
    .take_back(take_back), .back_addr(back_addr)
  );

  always_comb begin
    if (take_back)           pc_seq = back_addr;
    else if (pc == LAST_PC)  pc_seq = '0;
    else                     pc_seq = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st <= ST_RUN;
          pc <= req_start;
        end
        ST_RUN: begin
          if (is_last)      st <= ST_IDLE;
          else if (exc_hit) pc <= EXC_PC;
          else              pc <= pc_seq;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign ctrl_valid = running;
  assign cur_addr   = pc;
  assign cur_word   = running ? word : '0;
  assign done       = is_last;
endmodule

// File: rtl/patseq_chk.sv
module patseq_chk #(
  parameter int AW       = 6,
  parameter int EXC_ADDR = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_start,
  input logic          exc_tea,
  input logic          exc_hrst,
  input logic          exc_srst,
  input logic          ctrl_valid,
  input logic [AW-1:0] cur_addr,
  input logic [31:0]   cur_word,
  input logic          done
);
  logic any_exc;
  assign any_exc = exc_tea | exc_hrst | exc_srst;

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> ctrl_valid && cur_addr == $past(req_start));

  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> !req_ready);

  p_done_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctrl_valid && req_ready);

  p_done_on_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctrl_valid && cur_word[31]);

  p_exc_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid && cur_word[29] && !cur_word[31] && any_exc
    |=> ctrl_valid && cur_addr == AW'(EXC_ADDR));

  p_exc_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid && !cur_word[29] && !cur_word[30] && !cur_word[31] && any_exc
    |=> ctrl_valid && cur_addr == AW'($past(cur_addr) + 1'b1));
endmodule

bind patseq_top patseq_chk #(.AW($clog2(DEPTH)), .EXC_ADDR(EXC_ADDR)) u_patseq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_start(req_start), .exc_tea(exc_tea), .exc_hrst(exc_hrst),
  .exc_srst(exc_srst), .ctrl_valid(ctrl_valid), .cur_addr(cur_addr),
  .cur_word(cur_word), .done(done)
);

// File: tb/test_patseq_top.sv
module test_patseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;
  localparam logic [31:0] F_LAST = 32'h8000_0000;
  localparam logic [31:0] F_LOOP = 32'h4000_0000;
  localparam logic [31:0] F_EXEN = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_start = '0;
  logic [3:0]  loop_cnt = '0;
  logic        exc_tea = 1'b0, exc_hrst = 1'b0, exc_srst = 1'b0;
  logic        ctrl_valid;
  logic [5:0]  cur_addr;
  logic [31:0] cur_word;
  logic        done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] img [64];
  int exp_tr [256];
  int exp_n;

  patseq_top i_patseq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_start(req_start),
    .loop_cnt(loop_cnt), .exc_tea(exc_tea), .exc_hrst(exc_hrst), .exc_srst(exc_srst),
    .ctrl_valid(ctrl_valid), .cur_addr(cur_addr), .cur_word(cur_word), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic put(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    img[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tr_clear(); exp_n = 0; endtask
  task automatic tr_span(input int from, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_tr[exp_n] = (from + k) % 64;
      exp_n++;
    end
  endtask

  // Issue a request and follow the expected trace word by word.
  task automatic run(input int st, input int cnt, input int exc_at,
                     input logic [2:0] emask, input bit poke, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_start = 6'(st); loop_cnt = 4'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      chk(ctrl_valid == 1'b1, {tag, " valid"}, ctrl_valid, 1);
      chk(cur_addr == 6'(exp_tr[i]), {tag, " addr"}, cur_addr, exp_tr[i]);
      chk(cur_word == img[cur_addr], "R2 word", cur_word, img[cur_addr]);
      chk(done == (i == exp_n - 1), {tag, " R5 done"}, done, (i == exp_n - 1));
      if (poke && i == 1) begin
        req_valid = 1'b1; req_start = 6'd20;
        chk(req_ready == 1'b0, "R3 busy ready", req_ready, 0);
      end else begin
        req_valid = 1'b0;
      end
      {exc_srst, exc_hrst, exc_tea} = (int'(cur_addr) == exc_at) ? emask : 3'b000;
      @(negedge clk);
    end
    {exc_srst, exc_hrst, exc_tea} = 3'b000;
    req_valid = 1'b0;
    chk(!ctrl_valid && req_ready, {tag, " R5 idle"}, {ctrl_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(ctrl_valid == 1'b0, "R1 valid", ctrl_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;

    for (int a = 0; a < 64; a++) put(a, 32'(a * 32'h0101_0000 + a));

    // Loop body 7..10, stray loop mark at 11, end at 12 (R6, R7, R8)
    put(7,  F_LOOP | 32'h77);
    put(10, F_LOOP | 32'hAA);
    put(11, F_LOOP | 32'hBB);
    put(12, F_LAST | 32'hCC);
    for (int c = 15; c >= 0; c--) begin
      int passes;
      passes = (c == 0) ? 1 : c;
      tr_clear();
      tr_span(5, 2);
      for (int p = 0; p < passes; p++) tr_span(7, 4);
      tr_span(11, 2);
      run(5, c, -1, 3'b000, 0, "R6 R7 R8 loop sweep");
    end
    tr_clear(); tr_span(5, 2);
    for (int p = 0; p < 3; p++) tr_span(7, 4);
    tr_span(11, 2);
    run(5, 3, -1, 3'b000, 0, "R8 reload");

    // R4 wrap, with R3 request poked while busy
    put(1, F_LAST | 32'h11);
    tr_clear(); tr_span(62, 4);
    run(62, 0, -1, 3'b000, 1, "R4 R3 wrap");

    // R9: each exception source on an enabled word
    put(21, F_EXEN | 32'h21);
    put(23, F_LAST | 32'h23);
    put(61, F_LAST | 32'h61);
    tr_clear(); tr_span(20, 4);
    run(20, 0, -1, 3'b000, 0, "R9 baseline");
    for (int s = 0; s < 3; s++) begin
      tr_clear(); tr_span(20, 2); tr_span(60, 2);
      run(20, 0, 21, 3'(1 << s), 0, "R9 branch");
    end

    // R10: exception on a disabled word is dropped
    put(25, F_EXEN | 32'h25);
    put(26, F_LAST | 32'h26);
    tr_clear(); tr_span(24, 3);
    run(24, 0, 24, 3'b111, 0, "R10 ignore");

    // R11: end-of-pattern beats exception
    put(41, F_LAST | F_EXEN | 32'h41);
    tr_clear(); tr_span(40, 2);
    run(40, 0, 41, 3'b001, 0, "R11 last wins");

    // R12: exception inside a loop, handler starts its own loop
    put(31, F_LOOP | 32'h31);
    put(32, F_EXEN | 32'h32);
    put(33, F_LOOP | 32'h33);
    put(34, F_LAST | 32'h34);
    put(60, F_LOOP | 32'h60);
    put(61, 32'h61);
    put(62, F_LAST | 32'h62);
    tr_clear(); tr_span(30, 3); tr_span(60, 3);
    run(30, 3, 32, 3'b010, 0, "R12 flush");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule